// File: doc/BRIEF.md
# Mode-Dependent GPIO Port with Bus Strobe Overrides

This block is an eight-pin general-purpose I/O port that sits on a simple microcontroller peripheral bus. Software sees three registers: a write-only direction register, a read/write output data register and a read-only pin-state register. In single-chip operation every pin is plain GPIO. Each pin drives its data bit when its direction bit is set and floats otherwise.

In the expanded bus modes the port gives most of its pins to the external bus controller. Four pins always drive the memory strobes, whatever their direction bits hold. Two pins become bus inputs: wait and bus request. One pin drives the bus acknowledge. Only the top pin stays under software control. Pin inputs pass through a two-flop synchroniser. The synchronised wait and request levels are also handed back to the bus controller.

Hardware standby floats every pin and reloads the registers. The direction register reload value depends on the mode. Software standby freezes the registers and the driven levels. A standby hold enable input chooses whether the bus-owned pins keep their last level or float.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset the direction register holds 0x80 when `modeSel` is 4, 5 or 6 (expanded) and 0x00 for any other value (7 is single-chip). In expanded mode this gives `padOe` = 0xF9. In single-chip mode it gives `padOe` = 0x00.
- R2: The data register sits at address 0xFF0E and resets to 0x00. A write lands at the next rising edge, and a read returns the stored value in the same cycle. A read of any unmapped address returns 0x00.
- R3: The direction register sits at address 0xFE3E and is write-only. A read of that address returns 0xFF.
- R4: In single-chip mode, `padOe[i]` equals direction bit i and `padOut[i]` equals data bit i for every pin.
- R5: In expanded mode, pin 7 follows direction bit 7 and data bit 7. Pins 6..3 are always enabled and drive `busStrobes[3:0]`, where pin 6 is address strobe (bit 3) and pin 3 is low write strobe (bit 0). Their direction bits are ignored.
- R6: In expanded mode, pins 2 (wait) and 1 (bus request) are never enabled, and pin 0 is always enabled and drives `busAckOut`. `waitSync` and `busReqSync` show pad 2 and pad 1 after the second rising edge.
- R7: The pin-state register sits at address 0xFFBE. For an enabled pin it returns the driven level. For any other pin it returns the pad level synchronised over two rising edges.
- R8: A write to the pin-state address changes nothing. Writes to any address are ignored while either standby input is high.
- R9: While `hwStandby` is high, all of `padOe` is 0 in the same cycle. The registers reload their reset values (the direction value per R1, data 0x00).
- R10: While `swStandby` is high, both registers keep their values, and GPIO pins keep their enable and their driven level.
- R11: In software standby with expanded mode, the bus-owned pins (6..3 and 0) keep the level they drove in the cycle before entry if `standbyHoldEn` is 1, and are disabled if it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| modeSel | input | 3 | Operating mode: 4 to 6 expanded, other values single-chip |
| hwStandby | input | 1 | Hardware standby request |
| swStandby | input | 1 | Software standby request |
| standbyHoldEn | input | 1 | 1 = bus pins hold their level in software standby, 0 = bus pins float |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| busStrobes | input | 4 | Strobe levels from the bus controller (address, read, high write, low write) |
| busAckOut | input | 1 | Bus acknowledge level from the bus controller |
| waitSync | output | 1 | Synchronised wait input |
| busReqSync | output | 1 | Synchronised bus request input |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables |

## Verification
Register writes take effect at the rising edge that samples `busWrEn`. Reads and the standby overrides of `padOe` are combinational, so the bench checks them a short delay after it changes the address or the standby input. Pad inputs reach the pin-state register and the synchronised outputs only after two rising edges. The bench therefore drives `padIn` at a falling edge and checks the old value one falling edge later and the new value two falling edges later. All stimulus changes at falling edges, and every sample is taken between edges.

// File: rtl/gpio_bus_port_pkg.sv
package gpio_bus_port_pkg;

  localparam int PORT_W    = 8;
  localparam int STROBE_W  = 4;
  localparam int STROBE_LO = 3;
  localparam int PIN_WAIT  = 2;
  localparam int PIN_BREQ  = 1;
  localparam int PIN_BACK  = 0;

  typedef enum logic [1:0] {
    ROLE_GPIO,
    ROLE_STROBE,
    ROLE_BUSIN,
    ROLE_BUSOUT
  } pinRole_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_DIR,
    RD_DATA,
    RD_PIN
  } rdSel_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic              dirWr;
    logic              dataWr;
    logic [PORT_W-1:0] wrData;
    logic [PORT_W-1:0] dirInit;
    logic              loadInit;
    logic              expanded;
    logic              freezeBus;
    logic              holdBus;
    logic              forceTri;
    rdSel_e            rdSel;
  } portStrobes_t;

  // Role a pin takes when the port runs in an expanded bus mode
  function automatic pinRole_e pinRole(input int idx);
    if (idx >= STROBE_LO && idx < STROBE_LO + STROBE_W) return ROLE_STROBE;
    if (idx == PIN_WAIT || idx == PIN_BREQ) return ROLE_BUSIN;
    if (idx == PIN_BACK) return ROLE_BUSOUT;
    return ROLE_GPIO;
  endfunction

endpackage

// File: rtl/gpio_bus_port_ctrl.sv
module gpio_bus_port_ctrl
  import gpio_bus_port_pkg::*;
#(
  parameter int                MODE_W      = 3,
  parameter logic [MODE_W-1:0] MODE_EXP_LO = 3'd4,
  parameter logic [MODE_W-1:0] MODE_EXP_HI = 3'd6,
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFE3E,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFF0E,
  parameter logic [ADDR_W-1:0] PIN_ADDR    = 16'hFFBE
) (
  input  logic [MODE_W-1:0] modeSel,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic              standbyHoldEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  output portStrobes_t      strobes
);

  localparam logic [PORT_W-1:0] EXP_DIR_INIT = {1'b1, {(PORT_W-1){1'b0}}};

  logic   isExpanded;
  logic   wrAllowed;
  rdSel_e addrSel;

  assign isExpanded = (modeSel >= MODE_EXP_LO) && (modeSel <= MODE_EXP_HI);
  assign wrAllowed  = busWrEn && !hwStandby && !swStandby;

  always_comb begin
    if (busAddr == DIR_ADDR)       addrSel = RD_DIR;
    else if (busAddr == DATA_ADDR) addrSel = RD_DATA;
    else if (busAddr == PIN_ADDR)  addrSel = RD_PIN;
    else                           addrSel = RD_NONE;
  end

  always_comb begin
    strobes.dirWr     = wrAllowed && (addrSel == RD_DIR);
    strobes.dataWr    = wrAllowed && (addrSel == RD_DATA);
    strobes.wrData    = busWrData;
    strobes.dirInit   = isExpanded ? EXP_DIR_INIT : '0;
    strobes.loadInit  = hwStandby;
    strobes.expanded  = isExpanded;
    strobes.freezeBus = swStandby;
    strobes.holdBus   = standbyHoldEn;
    strobes.forceTri  = hwStandby;
    strobes.rdSel     = addrSel;
  end

endmodule

// File: rtl/gpio_bus_port_dp.sv
module gpio_bus_port_dp
  import gpio_bus_port_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  portStrobes_t        st,
  input  logic [STROBE_W-1:0] busStrobes,
  input  logic                busAckOut,
  input  logic [PORT_W-1:0]   padIn,
  output logic [PORT_W-1:0]   padOut,
  output logic [PORT_W-1:0]   padOe,
  output logic [PORT_W-1:0]   rdData,
  output logic                waitSync,
  output logic                busReqSync
);

  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] dataQ;
  logic [PORT_W-1:0] syncQ;
  logic [PORT_W-1:0] pinState;

  // Direction and data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= st.dirInit;
      dataQ <= '0;
    end else if (st.loadInit) begin
      dirQ  <= st.dirInit;
      dataQ <= '0;
    end else begin
      if (st.dirWr)  dirQ  <= st.wrData;
      if (st.dataWr) dataQ <= st.wrData;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    localparam pinRole_e ROLE = pinRole(i);

    logic metaBit;
    logic syncBit;
    logic holdBit;
    logic rawOut;
    logic rawOe;
    logic busOwned;

    // Two-flop input synchroniser
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaBit <= 1'b0;
        syncBit <= 1'b0;
      end else begin
        metaBit <= padIn[i];
        syncBit <= metaBit;
      end
    end
    assign syncQ[i] = syncBit;

    // Pick the pin source for its role
    if (ROLE == ROLE_STROBE) begin : g_strobe
      assign rawOut   = st.expanded ? busStrobes[i-STROBE_LO] : dataQ[i];
      assign rawOe    = st.expanded ? 1'b1 : dirQ[i];
      assign busOwned = st.expanded;
    end else if (ROLE == ROLE_BUSIN) begin : g_busin
      assign rawOut   = st.expanded ? 1'b0 : dataQ[i];
      assign rawOe    = st.expanded ? 1'b0 : dirQ[i];
      assign busOwned = 1'b0;
    end else if (ROLE == ROLE_BUSOUT) begin : g_busout
      assign rawOut   = st.expanded ? busAckOut : dataQ[i];
      assign rawOe    = st.expanded ? 1'b1 : dirQ[i];
      assign busOwned = st.expanded;
    end else begin : g_gpio
      assign rawOut   = dataQ[i];
      assign rawOe    = dirQ[i];
      assign busOwned = 1'b0;
    end

    // Level capture for software standby
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              holdBit <= 1'b0;
      else if (!st.freezeBus) holdBit <= rawOut;
    end

    assign padOut[i] = st.freezeBus ? holdBit : rawOut;

    always_comb begin
      if (st.forceTri)                  padOe[i] = 1'b0;
      else if (st.freezeBus && busOwned) padOe[i] = st.holdBus;
      else                              padOe[i] = rawOe;
    end

    assign pinState[i] = padOe[i] ? padOut[i] : syncBit;
  end

  assign waitSync   = syncQ[PIN_WAIT];
  assign busReqSync = syncQ[PIN_BREQ];

  always_comb begin
    unique case (st.rdSel)
      RD_DIR:  rdData = '1;
      RD_DATA: rdData = dataQ;
      RD_PIN:  rdData = pinState;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_bus_port_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFE3E,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFF0E,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFFBE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          modeSel,
  input  logic                hwStandby,
  input  logic                swStandby,
  input  logic                standbyHoldEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [PORT_W-1:0]   busWrData,
  output logic [PORT_W-1:0]   busRdData,
  input  logic [STROBE_W-1:0] busStrobes,
  input  logic                busAckOut,
  output logic                waitSync,
  output logic                busReqSync,
  input  logic [PORT_W-1:0]   padIn,
  output logic [PORT_W-1:0]   padOut,
  output logic [PORT_W-1:0]   padOe
);

  portStrobes_t strobes;

  gpio_bus_port_ctrl #(
    .MODE_W    (3),
    .ADDR_W    (ADDR_W),
    .DIR_ADDR  (DIR_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .PIN_ADDR  (PIN_ADDR)
  ) u_ctrl (
    .modeSel       (modeSel),
    .hwStandby     (hwStandby),
    .swStandby     (swStandby),
    .standbyHoldEn (standbyHoldEn),
    .busWrEn       (busWrEn),
    .busAddr       (busAddr),
    .busWrData     (busWrData),
    .strobes       (strobes)
  );

  gpio_bus_port_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .busStrobes (busStrobes),
    .busAckOut  (busAckOut),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .rdData     (busRdData),
    .waitSync   (waitSync),
    .busReqSync (busReqSync)
  );

endmodule

// File: rtl/gpio_bus_port_chk.sv
module gpio_bus_port_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE3E
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeSel,
  input logic              hwStandby,
  input logic              swStandby,
  input logic              standbyHoldEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busRdData,
  input logic [3:0]        busStrobes,
  input logic              busAckOut,
  input logic [7:0]        padOut,
  input logic [7:0]        padOe
);

  logic expMode;
  assign expMode = (modeSel >= 3'd4) && (modeSel <= 3'd6);

  // R9
  hw_standby_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |-> (padOe == 8'h00));

  // R5
  strobe_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expMode && !hwStandby && !swStandby) |->
      (padOe[6:3] == 4'hF) && (padOut[6:3] == busStrobes));

  // R6
  bus_pin_roles_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expMode && !hwStandby && !swStandby) |->
      (padOe[2:1] == 2'b00) && padOe[0] && (padOut[0] == busAckOut));

  // R11
  standby_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expMode && swStandby && !standbyHoldEn && !hwStandby) |->
      (padOe[6:3] == 4'h0) && !padOe[0]);

  // R11
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && $past(swStandby) && !hwStandby && !$past(hwStandby) && $stable(modeSel)) |->
      $stable(padOut));

  // R3
  dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DIR_ADDR) |-> (busRdData == 8'hFF));

endmodule

bind gpio_bus_port gpio_bus_port_chk #(
  .ADDR_W   (ADDR_W),
  .DIR_ADDR (DIR_ADDR)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .modeSel       (modeSel),
  .hwStandby     (hwStandby),
  .swStandby     (swStandby),
  .standbyHoldEn (standbyHoldEn),
  .busAddr       (busAddr),
  .busRdData     (busRdData),
  .busStrobes    (busStrobes),
  .busAckOut     (busAckOut),
  .padOut        (padOut),
  .padOe         (padOe)
);

// File: tb/gpio_bus_port_tb.sv
module gpio_bus_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [15:0] A_DIR  = 16'hFE3E;
  localparam logic [15:0] A_DATA = 16'hFF0E;
  localparam logic [15:0] A_PIN  = 16'hFFBE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = 3'd7;
  logic        hwStandby = 1'b0;
  logic        swStandby = 1'b0;
  logic        standbyHoldEn = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = 8'h00;
  logic [7:0]  busRdData;
  logic [3:0]  busStrobes = 4'h0;
  logic        busAckOut = 1'b0;
  logic        waitSync;
  logic        busReqSync;
  logic [7:0]  padIn = 8'h00;
  logic [7:0]  padOut;
  logic [7:0]  padOe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bus_port u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .hwStandby(hwStandby),
    .swStandby(swStandby), .standbyHoldEn(standbyHoldEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .busStrobes(busStrobes), .busAckOut(busAckOut), .waitSync(waitSync),
    .busReqSync(busReqSync), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] m);
    @(negedge clk);
    modeSel = m;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    busWrData = d;
    busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic tResetValues();
    logic [7:0] d;
    doReset(3'd7);
    chk("R1 single-chip reset enables", padOe, 8'h00);
    readReg(A_DATA, d);
    chk("R2 data reset value", d, 8'h00);
    doReset(3'd4);
    chk("R1 expanded reset enables", padOe, 8'hF9);
    readReg(A_DATA, d);
    chk("R2 data reset value expanded", d, 8'h00);
  endtask

  task automatic tRegisterAccess();
    logic [7:0] d;
    doReset(3'd7);
    writeReg(A_DATA, 8'hA5);
    readReg(A_DATA, d);
    chk("R2 data readback", d, 8'hA5);
    readReg(16'h1234, d);
    chk("R2 unmapped read", d, 8'h00);
    readReg(A_DIR, d);
    chk("R3 direction read", d, 8'hFF);
  endtask

  task automatic tSingleChip();
    writeReg(A_DIR, 8'h3C);
    chk("R4 single-chip enables", padOe, 8'h3C);
    chk("R4 single-chip levels", padOut, 8'hA5);
  endtask

  task automatic tPinStateSingle();
    logic [7:0] d;
    @(negedge clk);
    padIn = 8'h81;
    @(negedge clk);
    readReg(A_PIN, d);
    chk("R7 pin state after one edge", d, 8'h24);
    @(negedge clk);
    readReg(A_PIN, d);
    chk("R7 pin state after two edges", d, 8'hA5);
  endtask

  task automatic tIgnoredWrites();
    logic [7:0] d;
    writeReg(A_PIN, 8'hFF);
    readReg(A_DATA, d);
    chk("R8 pin-state write leaves data", d, 8'hA5);
    chk("R8 pin-state write leaves enables", padOe, 8'h3C);
    @(negedge clk);
    swStandby = 1'b1;
    writeReg(A_DATA, 8'h00);
    writeReg(A_DIR, 8'hFF);
    chk("R10 gpio enables kept in standby", padOe, 8'h3C);
    chk("R10 gpio levels kept in standby", padOut, 8'hA5);
    @(negedge clk);
    swStandby = 1'b0;
    readReg(A_DATA, d);
    chk("R8 data write in standby ignored", d, 8'hA5);
    chk("R8 direction write in standby ignored", padOe, 8'h3C);
  endtask

  task automatic tExpanded();
    doReset(3'd5);
    padIn = 8'h00;
    busStrobes = 4'b1010;
    busAckOut = 1'b1;
    writeReg(A_DIR, 8'h00);
    chk("R5 strobe pins ignore direction", padOe, 8'h79);
    writeReg(A_DIR, 8'h80);
    writeReg(A_DATA, 8'h80);
    chk("R5 expanded enables", padOe, 8'hF9);
    chk("R5 R6 expanded levels", padOut, 8'hD1);
  endtask

  task automatic tBusInputs();
    logic [7:0] d;
    @(negedge clk);
    padIn = 8'h04;
    @(negedge clk);
    chk("R6 wait after one edge", {7'd0, waitSync}, 8'h00);
    @(negedge clk);
    chk("R6 wait after two edges", {7'd0, waitSync}, 8'h01);
    chk("R6 bus request stays low", {7'd0, busReqSync}, 8'h00);
    readReg(A_PIN, d);
    chk("R7 pin state expanded", d, 8'hD5);
    @(negedge clk);
    padIn = 8'h02;
    @(negedge clk);
    @(negedge clk);
    chk("R6 bus request after two edges", {7'd0, busReqSync}, 8'h01);
  endtask

  task automatic tSoftStandby();
    @(negedge clk);
    standbyHoldEn = 1'b1;
    swStandby = 1'b1;
    busStrobes = 4'b0101;
    busAckOut = 1'b0;
    @(negedge clk);
    chk("R11 held levels", padOut, 8'hD1);
    chk("R11 held enables", padOe, 8'hF9);
    standbyHoldEn = 1'b0;
    #1;
    chk("R11 floated bus pins", padOe, 8'h80);
    chk("R11 floated levels unchanged", padOut, 8'hD1);
    @(negedge clk);
    swStandby = 1'b0;
    #1;
    chk("R5 live strobes after standby", padOut, 8'hA8);
    chk("R5 enables after standby", padOe, 8'hF9);
  endtask

  task automatic tHardStandby();
    logic [7:0] d;
    doReset(3'd7);
    writeReg(A_DIR, 8'h3C);
    writeReg(A_DATA, 8'h5A);
    @(negedge clk);
    hwStandby = 1'b1;
    #1;
    chk("R9 all pins float", padOe, 8'h00);
    @(negedge clk);
    hwStandby = 1'b0;
    #1;
    chk("R9 direction reloaded single-chip", padOe, 8'h00);
    readReg(A_DATA, d);
    chk("R9 data reloaded", d, 8'h00);
    doReset(3'd4);
    writeReg(A_DIR, 8'h00);
    chk("R9 expanded before standby", padOe, 8'h79);
    @(negedge clk);
    hwStandby = 1'b1;
    @(negedge clk);
    hwStandby = 1'b0;
    #1;
    chk("R9 R1 direction reloaded expanded", padOe, 8'hF9);
  endtask

  initial begin
    tResetValues();
    tRegisterAccess();
    tSingleChip();
    tPinStateSingle();
    tIgnoredWrites();
    tExpanded();
    tBusInputs();
    tSoftStandby();
    tHardStandby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule